// File: doc/BRIEF.md
# Graceful DMA Stop and Transmit Poll Controller

This block sits beside the DMA engine of an Ethernet controller. It watches writes to the DMA control register and carries out two of the register's duties. The first is the graceful stop handshake for the transmit and receive paths. The second is the periodic timer that asks the transmit descriptor logic to walk ring 0.

A graceful stop request completes at once when its path has no frame in flight. When a frame is in flight, completion waits for that frame's end-of-frame strobe. The completion appears as a one-cycle event pulse that feeds the interrupt event register.

The poll timer is armed by any control write that leaves the wait-or-poll bit clear, and it is stopped by any control write that sets it. While it is armed, it issues one poll request per interval. A poll request is withheld while the graceful transmit stop bit is held, but the timer keeps its rhythm.

Top module: `gstop_poll_ctrl`

## Requirements
- R1: While reset is asserted, and after it until the first control write, `gts_done`, `grs_done` and `poll_req` are all low.
- R2: A control write with `wr_grs`=1 while `rx_busy`=0 raises `grs_done` for exactly one cycle, in the cycle after the write.
- R3: A control write with `wr_grs`=1 while `rx_busy`=1 raises no event at the time of the write. The event is instead raised once, in the cycle after the first following `rx_eof` strobe.
- R4: A control write with the stop bit clear cancels a pending completion, and a later end-of-frame strobe then raises no event.
- R5: The transmit side behaves as R2 to R4 with `wr_gts`, `tx_busy`, `tx_eof` and `gts_done`.
- R6: A control write with `wr_wop`=0 restarts the timer from a count of one. The first `poll_req` pulse comes two cycles after the write cycle, and further pulses follow every POLL_CYCLES cycles.
- R7: While the held graceful transmit stop bit (the `wr_gts` value of the last control write) is 1, no `poll_req` pulse is issued.
- R8: A control write with `wr_wop`=1 stops the timer, and no `poll_req` follows until the next write with `wr_wop`=0.
- R9: An end-of-frame strobe with no pending request raises no event, and every event pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| wr_grs | input | 1 | Written graceful receive stop bit |
| wr_gts | input | 1 | Written graceful transmit stop bit |
| wr_wop | input | 1 | Written wait-or-poll bit (1 = no polling) |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_busy | input | 1 | Receive frame in progress |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| gts_done | output | 1 | Transmit stop complete pulse |
| grs_done | output | 1 | Receive stop complete pulse |
| poll_req | output | 1 | Request to walk transmit ring 0 |

## Verification
The bench builds the block with POLL_CYCLES set to 6 in place of the production default of 1,250,000. With that value, several complete poll periods fit inside a session of a few tens of cycles. The bench can therefore check the first-pulse latency and the spacing between pulses, as well as suppression during a transmit stop and the stop on wait-or-poll. The stop handshakes do not depend on the parameter. They are driven through immediate completion, deferred completion, cancellation and stray end-of-frame strobes on both paths.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

  // Completion event for this cycle; a write takes precedence over a strobe.
  function automatic logic stop_fires_now(logic wr, logic set, logic busy,
                                          logic pending, logic eof);
    return wr ? (set && !busy) : (pending && eof);
  endfunction

  // Whether a deferred completion is still awaited after this cycle.
  function automatic logic stop_pending_next(logic wr, logic set, logic busy,
                                             logic pending, logic eof);
    return wr ? (set && busy) : (pending && !eof);
  endfunction

  // Poll countdown: reload at expiry (count of one), otherwise count down.
  function automatic int unsigned poll_count_next(int unsigned cnt,
                                                  int unsigned interval);
    return (cnt == 1) ? interval : cnt - 1;
  endfunction

endpackage

// File: rtl/gsp_stop_unit.sv
module gsp_stop_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic set,
  input  logic busy,
  input  logic eof,
  output logic done
);
  import gsp_pkg::*;

  logic pending;
  logic fire_evt;
  logic pend_nxt;

  assign fire_evt = stop_fires_now(wr, set, busy, pending, eof);
  assign pend_nxt = stop_pending_next(wr, set, busy, pending, eof);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      done    <= 1'b0;
    end else begin
      pending <= pend_nxt;
      done    <= fire_evt;
    end
  end

  // R4
  cancel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !set) |=> (!done && !pending));

  // R3
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && set && busy) |=> (!done && pending));

  // R3
  pend_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !eof && !wr) |=> (!done && pending));

  // R9
  stray_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !pending) |=> !done);

endmodule

// File: rtl/gsp_poll_timer.sv
module gsp_poll_timer #(
  parameter int unsigned POLL_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wop,
  input  logic gts,
  output logic poll_req
);
  import gsp_pkg::*;

  localparam int CW = $clog2(POLL_CYCLES + 1);

  logic          running;
  logic [CW-1:0] count;
  logic          expire_evt;

  assign expire_evt = running && (count == CW'(1)) && !wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      count    <= CW'(1);
      poll_req <= 1'b0;
    end else if (wr) begin
      running  <= !wop;
      count    <= CW'(1);
      poll_req <= 1'b0;
    end else if (expire_evt) begin
      count    <= CW'(poll_count_next(32'(count), POLL_CYCLES));
      poll_req <= !gts;
    end else begin
      if (running) count <= CW'(poll_count_next(32'(count), POLL_CYCLES));
      poll_req <= 1'b0;
    end
  end

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wop) |=> (!poll_req && !running));

  // R7
  gts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gts |=> !poll_req);

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count >= CW'(1) && 32'(count) <= POLL_CYCLES));

  // R6
  poll_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && POLL_CYCLES > 1) |=> !poll_req);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr) |=> !poll_req);

endmodule

// File: rtl/gstop_poll_ctrl.sv
module gstop_poll_ctrl #(
  parameter int unsigned POLL_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_grs,
  input  logic wr_gts,
  input  logic wr_wop,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic tx_eof,
  input  logic rx_eof,
  output logic gts_done,
  output logic grs_done,
  output logic poll_req
);
  localparam int NPATH = 2;

  logic             gts_q;
  logic [NPATH-1:0] set_v;
  logic [NPATH-1:0] busy_v;
  logic [NPATH-1:0] eof_v;
  logic [NPATH-1:0] done_v;

  // Path 0 is transmit, path 1 is receive.
  assign set_v  = {wr_grs, wr_gts};
  assign busy_v = {rx_busy, tx_busy};
  assign eof_v  = {rx_eof, tx_eof};

  always_ff @(posedge clk) begin
    if (!rst_n)       gts_q <= 1'b0;
    else if (ctrl_wr) gts_q <= wr_gts;
  end

  for (genvar d = 0; d < NPATH; d++) begin : g_stop
    gsp_stop_unit u_stop (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctrl_wr),
      .set   (set_v[d]),
      .busy  (busy_v[d]),
      .eof   (eof_v[d]),
      .done  (done_v[d])
    );
  end

  assign gts_done = done_v[0];
  assign grs_done = done_v[1];

  gsp_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .wop      (wr_wop),
    .gts      (gts_q),
    .poll_req (poll_req)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!gts_done && !grs_done && !poll_req));

endmodule

// File: tb/tb_gstop_poll_ctrl.sv
module tb_gstop_poll_ctrl;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0, wr_grs = 1'b0, wr_gts = 1'b0, wr_wop = 1'b1;
  logic tx_busy = 1'b0, rx_busy = 1'b0, tx_eof = 1'b0, rx_eof = 1'b0;
  logic gts_done, grs_done, poll_req;

  gstop_poll_ctrl #(.POLL_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_grs(wr_grs),
    .wr_gts(wr_gts), .wr_wop(wr_wop), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .tx_eof(tx_eof), .rx_eof(rx_eof), .gts_done(gts_done),
    .grs_done(grs_done), .poll_req(poll_req)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   pend_tx = 0, pend_rx = 0;
  bit   done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void push(int kind, int at, string req);
    exp_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    exp_q.push_back(e);
  endfunction

  // Monitor: match each observed pulse against the scoreboard.
  always @(negedge clk) begin
    logic [2:0] obs;
    obs = {poll_req, grs_done, gts_done};
    if (!rst_n) begin
      checks++;
      if (obs != 3'b000) begin
        errors++;
        $display("FAIL R1 outputs in reset actual %b expected 000", obs);
      end
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (obs[k]) begin
          int hit;
          hit = -1;
          for (int i = 0; i < exp_q.size(); i++)
            if (hit < 0 && exp_q[i].kind == k && exp_q[i].cyc == cyc) hit = i;
          checks++;
          if (hit >= 0) exp_q.delete(hit);
          else begin
            errors++;
            $display("FAIL R9 unexpected pulse kind %0d at cycle %0d actual 1 expected 0", k, cyc);
          end
        end
      end
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc <= cyc) begin
          checks++;
          errors++;
          $display("FAIL %s missing pulse kind %0d at cycle %0d actual 0 expected 1",
                   exp_q[i].req, exp_q[i].kind, exp_q[i].cyc);
          exp_q.delete(i);
        end
      end
    end
  end

  task automatic write_ctrl(input bit grs, input bit gts, input bit wop,
                            input string req, output int n);
    @(negedge clk);
    n = cyc;
    ctrl_wr = 1'b1; wr_grs = grs; wr_gts = gts; wr_wop = wop;
    if (grs && !rx_busy) push(1, n + 1, req);
    if (gts && !tx_busy) push(0, n + 1, req);
    pend_rx = grs && rx_busy;
    pend_tx = gts && tx_busy;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic end_frame(input bit is_rx, input string req);
    @(negedge clk);
    if (is_rx) begin
      rx_eof = 1'b1; rx_busy = 1'b0;
      if (pend_rx) push(1, cyc + 1, req);
      pend_rx = 0;
    end else begin
      tx_eof = 1'b1; tx_busy = 1'b0;
      if (pend_tx) push(0, cyc + 1, req);
      pend_tx = 0;
    end
    @(negedge clk);
    rx_eof = 1'b0; tx_eof = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_session(input bit gts, input int len, input string req);
    int n, m;
    write_ctrl(0, gts, 0, req, n);
    if (!gts)
      for (int t = n + 2; t <= n + len; t += P) push(2, t, req);
    while (cyc < n + len - 1) @(negedge clk);
    write_ctrl(0, 0, 1, "R8", m);
  endtask

  initial begin
    int n;
    idle(4);
    rst_n = 1'b1;
    idle(5);                                  // R1 quiet after reset
    // R2 immediate receive stop
    write_ctrl(1, 0, 1, "R2", n);
    write_ctrl(0, 0, 1, "R2", n);
    idle(3);
    // R3 deferred receive stop, then stray eof (R9)
    rx_busy = 1'b1;
    write_ctrl(1, 0, 1, "R3", n);
    idle(4);
    end_frame(1, "R3");
    idle(3);
    end_frame(1, "R9");
    idle(3);
    // R4 cancel before end of frame
    rx_busy = 1'b1;
    write_ctrl(1, 0, 1, "R4", n);
    idle(2);
    write_ctrl(0, 0, 1, "R4", n);
    end_frame(1, "R4");
    idle(3);
    // R5 transmit immediate, deferred, cancel
    write_ctrl(0, 1, 1, "R5", n);
    write_ctrl(0, 0, 1, "R5", n);
    tx_busy = 1'b1;
    write_ctrl(0, 1, 1, "R5", n);
    idle(3);
    end_frame(0, "R5");
    idle(2);
    tx_busy = 1'b1;
    write_ctrl(0, 1, 1, "R5", n);
    write_ctrl(0, 0, 1, "R5", n);
    end_frame(0, "R5");
    idle(3);
    // R6 polling, then R8 stop
    poll_session(0, 30, "R6");
    idle(20);
    // R6 restart with an odd length
    poll_session(0, 17, "R6");
    idle(10);
    // R7 polling suppressed while transmit stop held
    poll_session(1, 25, "R7");
    idle(15);
    // both stops at once while both paths idle
    write_ctrl(1, 1, 1, "R2", n);
    write_ctrl(0, 0, 1, "R5", n);
    idle(5);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule